// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the timing strobes that pace a raster LCD panel. It sits between the display data path and the panel pins. From the system clock it derives a pixel-rate enable. It then walks every scan line through four stages, each measured in pixel periods: a leading wait, the visible pixels, a trailing wait and the line sync pulse. Lines are counted into frames. The frame sync is raised during the line sync of the first lines of each frame. An alternating bias output flips after a programmed number of completed lines.

The data path uses a one-cycle pixel request strobe to know when to present the next pixel. Software drives the configuration inputs. The block copies them into a shadow set when it is enabled and again at each frame boundary, so a change made mid-frame never tears a frame. The three sync-style outputs each have their own polarity select. Dropping the enable returns every output to its idle level.

Top module: `lcd_timing_gen`

## Requirements
- R1: While the block is disabled or just out of reset, `pix_tick`, `pix_req` and `lcd_acb` are 0. `lcd_oe`, `lcd_lclk` and `lcd_fclk` sit at their inactive level, which equals their polarity bit. All outputs read 0 in the first cycle after reset.
- R2: Once enabled, `pix_tick` pulses for one cycle every D system cycles. D is `cfg_div`, limited to the range 2 to 512. The first pulse comes D cycles after the enabling edge.
- R3: Each line runs `cfg_lead` pixel periods of leading wait, then `cfg_ppl` visible pixels, then `cfg_trail` trailing wait, then the line sync. `cfg_ppl` of 0 counts as 1 and values above 1024 count as 1024. A wait of 0 skips that stage.
- R4: `lcd_oe` is active exactly during the visible stage. `pix_req` pulses once per visible pixel, together with `pix_tick`.
- R5: The line sync `lcd_lclk` is active for `cfg_lsw` pixel periods at the end of each line. A value of 0 counts as 1.
- R6: A frame is `cfg_lpf` lines, with 0 counting as 1 and a ceiling of 1024. `lcd_fclk` is active during the line sync of the first `cfg_fsw` lines of each frame, where 0 counts as 1.
- R7: `lcd_acb` starts at 0 when the block is enabled. It inverts each time `cfg_acb` further lines have completed, where 0 counts as 1, and its count carries across frames.
- R8: A polarity bit of 1 makes the matching output (`cfg_pol_oe`, `cfg_pol_lclk`, `cfg_pol_fclk`) active-low. A bit of 0 makes it active-high.
- R9: Configuration changes take effect only at the next frame boundary. The frame in progress finishes with the old settings.
- R10: Deasserting `en` returns all outputs to their idle levels by the second clock edge. No further `pix_tick` occurs until the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; rising starts a frame |
| cfg_ppl | input | 11 | Visible pixels per line |
| cfg_lpf | input | 11 | Lines per frame |
| cfg_lead | input | 8 | Leading wait in pixel periods |
| cfg_trail | input | 8 | Trailing wait in pixel periods |
| cfg_lsw | input | 8 | Line sync width in pixel periods |
| cfg_fsw | input | 11 | Number of leading lines carrying frame sync |
| cfg_acb | input | 8 | Lines between bias inversions |
| cfg_div | input | 10 | System cycles per pixel period |
| cfg_pol_oe | input | 1 | Output enable active-low when 1 |
| cfg_pol_fclk | input | 1 | Frame sync active-low when 1 |
| cfg_pol_lclk | input | 1 | Line sync active-low when 1 |
| pix_tick | output | 1 | One-cycle pixel rate pulse |
| pix_req | output | 1 | One-cycle request for the next visible pixel |
| lcd_oe | output | 1 | Output enable pin |
| lcd_lclk | output | 1 | Line sync pin |
| lcd_fclk | output | 1 | Frame sync pin |
| lcd_acb | output | 1 | Alternating bias pin |

## Verification
A wrong stage or pixel counter shows up within one pixel period as a misplaced edge on `lcd_oe` or `lcd_lclk`. It also changes the count of `pix_req` pulses in that line. A faulty line counter first shows at the next line sync, as a frame sync on the wrong line. A faulty bias counter only shows at the next inversion, up to `cfg_acb` lines later. A shadow load at the wrong moment appears at the first frame boundary as a wrong per-frame request count. The bench therefore compares every output in every cycle across whole frames against an arithmetic model, for several small configurations.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  parameter int MAX_PIX   = 1024;
  parameter int MAX_LINES = 1024;
  parameter int WAIT_W    = 8;
  parameter int PW_W      = 8;
  parameter int ACB_W     = 8;
  parameter int DIV_MIN   = 2;
  parameter int DIV_MAX   = 512;

  localparam int PPL_W  = $clog2(MAX_PIX + 1);
  localparam int LPF_W  = $clog2(MAX_LINES + 1);
  localparam int DIV_W  = $clog2(DIV_MAX + 1);
  localparam int DCNT_W = $clog2(DIV_MAX);
  localparam int HW_A   = (PPL_W > WAIT_W) ? PPL_W : WAIT_W;
  localparam int HCNT_W = (HW_A > PW_W) ? HW_A : PW_W;

  typedef enum logic [1:0] {
    PH_LEAD  = 2'd0,
    PH_PIX   = 2'd1,
    PH_TRAIL = 2'd2,
    PH_LSYNC = 2'd3
  } phase_e;

  typedef struct packed {
    logic [PPL_W-1:0]  ppl;
    logic [LPF_W-1:0]  lpf;
    logic [WAIT_W-1:0] lead;
    logic [WAIT_W-1:0] trail;
    logic [PW_W-1:0]   lsw;
    logic [LPF_W-1:0]  fsw;
    logic [ACB_W-1:0]  acb;
    logic [DIV_W-1:0]  div;
    logic              pol_oe;
    logic              pol_fclk;
    logic              pol_lclk;
  } tcfg_t;
endpackage

// File: rtl/lcd_tg_cfg.sv
module lcd_tg_cfg
  import lcd_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  tcfg_t             raw,
  output logic [WAIT_W-1:0] nxt_lead,
  output logic              nxt_pol_oe,
  output logic              nxt_pol_fclk,
  output logic              nxt_pol_lclk,
  output tcfg_t             cur
);
  tcfg_t lim;

  // Clamp live settings into their legal ranges
  always_comb begin
    lim = raw;
    if (raw.ppl == '0)
      lim.ppl = PPL_W'(1);
    else if (raw.ppl > PPL_W'(MAX_PIX))
      lim.ppl = PPL_W'(MAX_PIX);
    if (raw.lpf == '0)
      lim.lpf = LPF_W'(1);
    else if (raw.lpf > LPF_W'(MAX_LINES))
      lim.lpf = LPF_W'(MAX_LINES);
    if (raw.lsw == '0) lim.lsw = PW_W'(1);
    if (raw.fsw == '0) lim.fsw = LPF_W'(1);
    if (raw.acb == '0) lim.acb = ACB_W'(1);
    if (raw.div < DIV_W'(DIV_MIN))
      lim.div = DIV_W'(DIV_MIN);
    else if (raw.div > DIV_W'(DIV_MAX))
      lim.div = DIV_W'(DIV_MAX);
  end

  assign nxt_lead     = lim.lead;
  assign nxt_pol_oe   = lim.pol_oe;
  assign nxt_pol_fclk = lim.pol_fclk;
  assign nxt_pol_lclk = lim.pol_lclk;

  // Shadow copy, refreshed only on start or frame boundary
  always_ff @(posedge clk) begin
    if (rst)
      cur <= '0;
    else if (load)
      cur <= lim;
  end
endmodule

// File: rtl/lcd_tg_div.sv
module lcd_tg_div
  import lcd_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DCNT_W-1:0] cnt;
  logic              wrap;

  assign wrap = (DIV_W'(cnt) == (div - DIV_W'(1)));
  assign tick = run && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (wrap)
      cnt <= '0;
    else
      cnt <= cnt + DCNT_W'(1);
  end

  // R2: pixel pulses are never back to back (divisor at least 2)
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R2: counter stays below the divisor while running
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (DIV_W'(cnt) < div));
endmodule

// File: rtl/lcd_tg_line.sv
module lcd_tg_line
  import lcd_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              start,
  input  logic              tick,
  input  logic              frame_last,
  input  logic [WAIT_W-1:0] nxt_lead,
  input  logic [PPL_W-1:0]  ppl,
  input  logic [WAIT_W-1:0] lead,
  input  logic [WAIT_W-1:0] trail,
  input  logic [PW_W-1:0]   lsw,
  output phase_e            phase,
  output logic              line_end
);
  logic [HCNT_W-1:0] hcnt;
  logic [HCNT_W-1:0] len;
  logic              last_slot;
  logic [WAIT_W-1:0] lead_sel;
  phase_e            ph_next;

  always_comb begin
    case (phase)
      PH_LEAD:  len = HCNT_W'(lead);
      PH_PIX:   len = HCNT_W'(ppl);
      PH_TRAIL: len = HCNT_W'(trail);
      default:  len = HCNT_W'(lsw);
    endcase
  end

  assign last_slot = (hcnt == (len - HCNT_W'(1)));
  assign line_end  = run && tick && (phase == PH_LSYNC) && last_slot;
  // At a frame boundary the next line already uses the new settings
  assign lead_sel  = frame_last ? nxt_lead : lead;

  always_comb begin
    case (phase)
      PH_LEAD:  ph_next = PH_PIX;
      PH_PIX:   ph_next = (trail != '0) ? PH_TRAIL : PH_LSYNC;
      PH_TRAIL: ph_next = PH_LSYNC;
      default:  ph_next = (lead_sel != '0) ? PH_LEAD : PH_PIX;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_LEAD;
      hcnt  <= '0;
    end else if (start) begin
      phase <= (nxt_lead != '0) ? PH_LEAD : PH_PIX;
      hcnt  <= '0;
    end else if (run && tick) begin
      if (last_slot) begin
        phase <= ph_next;
        hcnt  <= '0;
      end else begin
        hcnt <= hcnt + HCNT_W'(1);
      end
    end
  end

  // R3: position never runs past the length of the current stage
  a_r3_hcnt_range: assert property (@(posedge clk) disable iff (rst)
    (run && !start) |-> (hcnt < len));
  // R5: line sync holds until its last pixel period completes
  a_r5_lsync_hold: assert property (@(posedge clk) disable iff (rst)
    (run && tick && phase == PH_LSYNC && !line_end) |=> (phase == PH_LSYNC));
endmodule

// File: rtl/lcd_tg_frame.sv
module lcd_tg_frame
  import lcd_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             start,
  input  logic             line_end,
  input  logic [LPF_W-1:0] lpf,
  input  logic [LPF_W-1:0] fsw,
  input  logic [ACB_W-1:0] acb,
  output logic             frame_last,
  output logic             frame_end,
  output logic             fwin,
  output logic             acb_q
);
  logic [LPF_W-1:0] vcnt;
  logic [ACB_W-1:0] acnt;

  assign frame_last = (vcnt == (lpf - LPF_W'(1)));
  assign frame_end  = line_end && frame_last;
  assign fwin       = (vcnt < fsw);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      vcnt  <= '0;
      acnt  <= '0;
      acb_q <= 1'b0;
    end else if (line_end) begin
      vcnt <= frame_last ? '0 : (vcnt + LPF_W'(1));
      if (acnt >= (acb - ACB_W'(1))) begin
        acnt  <= '0;
        acb_q <= !acb_q;
      end else begin
        acnt <= acnt + ACB_W'(1);
      end
    end
  end

  // R6: line index stays inside the frame
  a_r6_vcnt_range: assert property (@(posedge clk) disable iff (rst)
    (run && !start) |-> (vcnt < lpf));
  // R7: bias level moves only at the close of a line
  a_r7_acb_on_line: assert property (@(posedge clk) disable iff (rst)
    (!line_end && !start) |=> $stable(acb_q));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PPL_W-1:0]  cfg_ppl,
  input  logic [LPF_W-1:0]  cfg_lpf,
  input  logic [WAIT_W-1:0] cfg_lead,
  input  logic [WAIT_W-1:0] cfg_trail,
  input  logic [PW_W-1:0]   cfg_lsw,
  input  logic [LPF_W-1:0]  cfg_fsw,
  input  logic [ACB_W-1:0]  cfg_acb,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_pol_oe,
  input  logic              cfg_pol_fclk,
  input  logic              cfg_pol_lclk,
  output logic              pix_tick,
  output logic              pix_req,
  output logic              lcd_oe,
  output logic              lcd_lclk,
  output logic              lcd_fclk,
  output logic              lcd_acb
);
  tcfg_t             raw;
  tcfg_t             cur;
  logic [WAIT_W-1:0] nxt_lead;
  logic              nxt_pol_oe;
  logic              nxt_pol_fclk;
  logic              nxt_pol_lclk;
  logic              run;
  logic              start;
  logic              tick;
  logic              line_end;
  logic              frame_last;
  logic              frame_end;
  logic              fwin;
  logic              acb_q;
  phase_e            phase;
  logic              oe_act_q;
  logic              lclk_act_q;
  logic              fclk_act_q;

  always_comb begin
    raw.ppl      = cfg_ppl;
    raw.lpf      = cfg_lpf;
    raw.lead     = cfg_lead;
    raw.trail    = cfg_trail;
    raw.lsw      = cfg_lsw;
    raw.fsw      = cfg_fsw;
    raw.acb      = cfg_acb;
    raw.div      = cfg_div;
    raw.pol_oe   = cfg_pol_oe;
    raw.pol_fclk = cfg_pol_fclk;
    raw.pol_lclk = cfg_pol_lclk;
  end

  assign start = en && !run;

  always_ff @(posedge clk) begin
    if (rst) run <= 1'b0;
    else     run <= en;
  end

  lcd_tg_cfg u_cfg (
    .clk          (clk),
    .rst          (rst),
    .load         (start || frame_end),
    .raw          (raw),
    .nxt_lead     (nxt_lead),
    .nxt_pol_oe   (nxt_pol_oe),
    .nxt_pol_fclk (nxt_pol_fclk),
    .nxt_pol_lclk (nxt_pol_lclk),
    .cur          (cur)
  );

  lcd_tg_div u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .div  (cur.div),
    .tick (tick)
  );

  lcd_tg_line u_line (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .start      (start),
    .tick       (tick),
    .frame_last (frame_last),
    .nxt_lead   (nxt_lead),
    .ppl        (cur.ppl),
    .lead       (cur.lead),
    .trail      (cur.trail),
    .lsw        (cur.lsw),
    .phase      (phase),
    .line_end   (line_end)
  );

  lcd_tg_frame u_frame (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .start      (start),
    .line_end   (line_end),
    .lpf        (cur.lpf),
    .fsw        (cur.fsw),
    .acb        (cur.acb),
    .frame_last (frame_last),
    .frame_end  (frame_end),
    .fwin       (fwin),
    .acb_q      (acb_q)
  );

  // Registered pin stage
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_tick   <= 1'b0;
      pix_req    <= 1'b0;
      lcd_oe     <= 1'b0;
      lcd_lclk   <= 1'b0;
      lcd_fclk   <= 1'b0;
      lcd_acb    <= 1'b0;
      oe_act_q   <= 1'b0;
      lclk_act_q <= 1'b0;
      fclk_act_q <= 1'b0;
    end else begin
      pix_tick   <= tick;
      pix_req    <= tick && (phase == PH_PIX);
      oe_act_q   <= run && (phase == PH_PIX);
      lclk_act_q <= run && (phase == PH_LSYNC);
      fclk_act_q <= run && (phase == PH_LSYNC) && fwin;
      lcd_acb    <= run && acb_q;
      if (run) begin
        lcd_oe   <= (phase == PH_PIX) ^ cur.pol_oe;
        lcd_lclk <= (phase == PH_LSYNC) ^ cur.pol_lclk;
        lcd_fclk <= ((phase == PH_LSYNC) && fwin) ^ cur.pol_fclk;
      end else begin
        lcd_oe   <= nxt_pol_oe;
        lcd_lclk <= nxt_pol_lclk;
        lcd_fclk <= nxt_pol_fclk;
      end
    end
  end

  // R4: a pixel request only during the visible stage
  a_r4_req_in_oe: assert property (@(posedge clk) disable iff (rst)
    pix_req |-> oe_act_q);
  // R4: a pixel request always coincides with the pixel pulse
  a_r4_req_tick: assert property (@(posedge clk) disable iff (rst)
    pix_req |-> pix_tick);
  // R3: visible stage and line sync never overlap
  a_r3_oe_lclk_excl: assert property (@(posedge clk) disable iff (rst)
    !(oe_act_q && lclk_act_q));
  // R6: frame sync only inside a line sync
  a_r6_fclk_in_lclk: assert property (@(posedge clk) disable iff (rst)
    fclk_act_q |-> lclk_act_q);
  // R10: a stopped generator emits no pulses
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!pix_tick && !pix_req));
endmodule

// File: tb/lcd_timing_gen_bench.sv
`timescale 1ns/1ps
module lcd_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [10:0] cfg_ppl = '0;
  logic [10:0] cfg_lpf = '0;
  logic [7:0]  cfg_lead = '0;
  logic [7:0]  cfg_trail = '0;
  logic [7:0]  cfg_lsw = '0;
  logic [10:0] cfg_fsw = '0;
  logic [7:0]  cfg_acb = '0;
  logic [9:0]  cfg_div = '0;
  logic        cfg_pol_oe = 1'b0;
  logic        cfg_pol_fclk = 1'b0;
  logic        cfg_pol_lclk = 1'b0;
  logic        pix_tick, pix_req, lcd_oe, lcd_lclk, lcd_fclk, lcd_acb;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lcd_timing_gen u_lcd_timing_gen (
    .clk(clk), .rst(rst), .en(en),
    .cfg_ppl(cfg_ppl), .cfg_lpf(cfg_lpf), .cfg_lead(cfg_lead),
    .cfg_trail(cfg_trail), .cfg_lsw(cfg_lsw), .cfg_fsw(cfg_fsw),
    .cfg_acb(cfg_acb), .cfg_div(cfg_div), .cfg_pol_oe(cfg_pol_oe),
    .cfg_pol_fclk(cfg_pol_fclk), .cfg_pol_lclk(cfg_pol_lclk),
    .pix_tick(pix_tick), .pix_req(pix_req), .lcd_oe(lcd_oe),
    .lcd_lclk(lcd_lclk), .lcd_fclk(lcd_fclk), .lcd_acb(lcd_acb)
  );

  function automatic logic [5:0] outs();
    return {pix_tick, pix_req, lcd_oe, lcd_lclk, lcd_fclk, lcd_acb};
  endfunction

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(int ppl, int lpf, int lead, int trail, int lsw,
                         int fsw, int acb, int div, bit po, bit pf, bit pl);
    cfg_ppl = 11'(ppl); cfg_lpf = 11'(lpf); cfg_lead = 8'(lead);
    cfg_trail = 8'(trail); cfg_lsw = 8'(lsw); cfg_fsw = 11'(fsw);
    cfg_acb = 8'(acb); cfg_div = 10'(div);
    cfg_pol_oe = po; cfg_pol_fclk = pf; cfg_pol_lclk = pl;
  endtask

  // Whole-frame, cycle-by-cycle comparison against the arithmetic model
  task automatic sweep(string tag, int ppl, int lpf, int lead, int trail,
                       int lsw, int fsw, int acb, int div,
                       bit po, bit pf, bit pl, int nframes);
    int ep, el, ew, efs, eab, ed, len_l, ncyc;
    ep  = (ppl == 0) ? 1 : ((ppl > 1024) ? 1024 : ppl);
    el  = (lpf == 0) ? 1 : ((lpf > 1024) ? 1024 : lpf);
    ew  = (lsw == 0) ? 1 : lsw;
    efs = (fsw == 0) ? 1 : fsw;
    eab = (acb == 0) ? 1 : acb;
    ed  = (div < 2) ? 2 : ((div > 512) ? 512 : div);
    len_l = lead + ep + trail + ew;
    ncyc  = len_l * el * ed * nframes;
    @(negedge clk);
    set_cfg(ppl, lpf, lead, trail, lsw, fsw, acb, div, po, pf, pl);
    en = 1'b1;
    @(posedge clk);
    for (int e = 1; e <= ncyc; e++) begin
      int s, ln, h;
      bit tk, a_oe, a_l, a_f, ab;
      @(posedge clk);
      #1;
      s    = (e - 1) / ed;
      tk   = (((e - 1) % ed) == ed - 1);
      ln   = s / len_l;
      h    = s % len_l;
      a_oe = (h >= lead) && (h < lead + ep);
      a_l  = (h >= lead + ep + trail);
      a_f  = a_l && ((ln % el) < efs);
      ab   = ((ln / eab) % 2) == 1;
      chk(tag, outs(), {tk, tk & a_oe, a_oe ^ po, a_l ^ pl, a_f ^ pf, ab});
    end
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cnt_a, cnt_b, tick_seen;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: first cycle after reset, everything low
    chk("R1 reset", outs(), 6'b000000);
    repeat (2) @(negedge clk);
    chk("R1 idle pol0", outs(), 6'b000000);
    // R8 / R1: idle level follows the polarity bits
    cfg_pol_oe = 1'b1; cfg_pol_fclk = 1'b1; cfg_pol_lclk = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 R1 idle pol1", outs(), 6'b001110);
    cfg_pol_oe = 1'b0; cfg_pol_fclk = 1'b0; cfg_pol_lclk = 1'b0;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R6 R7 with both waits present
    sweep("R2/R3/R4/R5/R6/R7 base", 3, 3, 1, 2, 2, 1, 2, 2, 0, 0, 0, 2);
    // R3 zero waits skipped, R8 active-low, R6 two sync lines, R7 period 3
    sweep("R3/R6/R7/R8 nowait", 4, 2, 0, 0, 1, 2, 3, 3, 1, 1, 1, 3);
    // R2 R3 R5 R6 R7 zero values clamp to their minimum
    sweep("R2/R3/R5/R6/R7 clamp", 0, 4, 3, 1, 0, 0, 0, 0, 1, 0, 0, 2);
    // R2 divisor ceiling at 512
    sweep("R2 divmax", 2, 1, 0, 0, 1, 1, 1, 600, 0, 0, 0, 2);
    // R3 pixel count ceiling at 1024
    sweep("R3 pplmax", 1100, 1, 0, 0, 1, 1, 1, 2, 0, 0, 0, 1);

    // R9: mid-frame change applies from the next frame
    @(negedge clk);
    set_cfg(3, 3, 1, 2, 2, 1, 2, 2, 0, 0, 0);
    en = 1'b1;
    @(posedge clk);
    cnt_a = 0; cnt_b = 0;
    for (int e = 1; e <= 48 + 30; e++) begin
      @(posedge clk);
      #1;
      if (pix_req) begin
        if (e <= 48) cnt_a++;
        else         cnt_b++;
      end
      if (e == 10) set_cfg(4, 2, 0, 0, 1, 1, 1, 3, 0, 0, 0);
    end
    chk_int("R9 old frame reqs", cnt_a, 9);
    chk_int("R9 new frame reqs", cnt_b, 8);

    // R10: stop mid-line
    repeat (7) @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk("R10 stopped idle", outs(), 6'b000000);
    tick_seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pix_tick || lcd_acb) tick_seen++;
    end
    chk_int("R10 no ticks after stop", tick_seen, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule